// File: doc/BRIEF.md
# Set/Clear Interrupt Controller

This block gathers up to 32 interrupt inputs and presents them to a processor as two request lines and one wake line. Software reaches it through a small register bus. Each control register has one address where written ones are OR-ed in, and a second address where written ones are cleared. The first address also reads back the current value. Every source has three configuration planes that together form its trigger code. It also has a mask bit, a wake-enable bit and a routing bit that chooses between request 0 and request 1.

Each input is resynchronised by two flops. It is then qualified either as a level or as an edge. Rising and falling edges are held in two sticky capture registers until software clears them by writing ones. For each request output there is a readable vector of pending sources. Those reads share addresses with two clear-write addresses, so a read and a write at the same address do different things. A scratch test register completes the map.

Top module: `irq_setclr_ctrl`

## Requirements
- R1: After reset, the three configuration planes, routing, wake and mask read as zero. The source-select register (read 0x58) reads all ones. Both capture registers and the test register read zero, and req0_o, req1_o and wake_o are low.
- R2: The set/clear register pairs sit at these offsets: configuration plane 0 at 0x40/0x44, plane 1 at 0x48/0x4C, plane 2 at 0x50/0x54, source-select at 0x58/0x5C, routing at 0x60/0x64, wake at 0x68/0x6C, mask at 0x70/0x74. The first offset of each pair is the set address and the second is the clear address. A write to a set address ORs the data into the register. A write to a clear address removes every bit that is one in the data. Reading the set address returns the present value.
- R3: The trigger code of source k is {plane2[k], plane1[k], plane0[k]}. 001 selects rising edge, 010 falling edge, 011 both edges, 101 high level and 110 low level. The codes 000, 100 and 111 never make the source pending.
- R4: An input change reaches the request output through two synchronising flops and one output flop. A level trigger changes the request on the third rising clock edge after the input changes. An edge trigger raises it on the fourth rising clock edge.
- R5: An edge is captured only when the trigger code enables that direction. A captured bit stays set after the input returns. Writing ones to 0x78 clears rising captures and writing ones to 0x7C clears falling captures. These two addresses read the rising and falling capture vectors.
- R6: A source is pending only while its mask bit is one. A change of a mask bit shows on the request output on the first rising clock edge after the write.
- R7: A pending source with routing bit 0 drives req0_o and one with routing bit 1 drives req1_o. A read of 0x54 returns the request-0 pending vector and a read of 0x5C returns the request-1 pending vector.
- R8: wake_o is high when a pending source has its wake bit set. It follows a wake-bit write on the first rising clock edge after it.
- R9: The test register at 0x80 is written directly and read back at the same offset. Its value has no effect on the outputs.
- R10: Read data appears on bus_rdata one clock after bus_rd is sampled. An offset that has no read meaning returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW (8) | Byte offset |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data |
| src_in | input | NSRC (32) | Asynchronous interrupt inputs |
| req0_o | output | 1 | Request line 0 |
| req1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wake line |

## Verification
An input change counts as clock 0. A level result is due on the third rising edge after it and an edge result on the fourth. Register writes reach the outputs on the first edge after the write, and reads return one clock after the strobe. Every stimulus is driven at a falling edge, and the bench counts falling edges to sample the outputs. It checks that the output has not yet moved one edge before the due edge, and that it has moved on the due edge itself. Sticky captures are checked again several cycles after the input has returned to show they stay set until cleared.

// File: rtl/irq_sc_pkg.sv
package irq_sc_pkg;
  // indices of the set/clear register planes
  localparam int SC_COUNT = 7;
  localparam int IX_CFG0  = 0;
  localparam int IX_CFG1  = 1;
  localparam int IX_CFG2  = 2;
  localparam int IX_SRC   = 3;
  localparam int IX_ROUTE = 4;
  localparam int IX_WAKE  = 5;
  localparam int IX_MASK  = 6;

  // address map
  localparam int OFS_SC_BASE   = 'h40;
  localparam int OFS_SC_STRIDE = 8;
  localparam int OFS_CLR_DELTA = 4;
  localparam int OFS_PEND0     = 'h54;
  localparam int OFS_PEND1     = 'h5C;
  localparam int OFS_RISE      = 'h78;
  localparam int OFS_FALL      = 'h7C;
  localparam int OFS_TEST      = 'h80;

  // trigger codes {plane2, plane1, plane0}
  localparam logic [2:0] TRIG_RISE = 3'b001;
  localparam logic [2:0] TRIG_FALL = 3'b010;
  localparam logic [2:0] TRIG_BOTH = 3'b011;
  localparam logic [2:0] TRIG_HIGH = 3'b101;
  localparam logic [2:0] TRIG_LOW  = 3'b110;

  function automatic logic trig_rise_on(input logic [2:0] code);
    return (code == TRIG_RISE) || (code == TRIG_BOTH);
  endfunction

  function automatic logic trig_fall_on(input logic [2:0] code);
    return (code == TRIG_FALL) || (code == TRIG_BOTH);
  endfunction
endpackage

// File: rtl/irq_sc_regs.sv
module irq_sc_regs
  import irq_sc_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 addr,
  input  logic [DW-1:0]                 wdata,
  output logic [SC_COUNT-1:0][NSRC-1:0] sc_o,
  output logic [DW-1:0]                 test_o,
  output logic [NSRC-1:0]               rise_clr_o,
  output logic [NSRC-1:0]               fall_clr_o
);
  logic [NSRC-1:0] wbits;
  assign wbits = wdata[NSRC-1:0];

  for (genvar i = 0; i < SC_COUNT; i++) begin : g_plane
    localparam logic [AW-1:0] SET_A = AW'(OFS_SC_BASE + OFS_SC_STRIDE * i);
    localparam logic [AW-1:0] CLR_A = AW'(OFS_SC_BASE + OFS_SC_STRIDE * i + OFS_CLR_DELTA);
    localparam logic [NSRC-1:0] RST_V = (i == IX_SRC) ? '1 : '0;
    logic [NSRC-1:0] plane_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        plane_q <= RST_V;
      end else if (wr_en && addr == SET_A) begin
        plane_q <= plane_q | wbits;
      end else if (wr_en && addr == CLR_A) begin
        plane_q <= plane_q & ~wbits;
      end
    end

    assign sc_o[i] = plane_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      test_o <= '0;
    end else if (wr_en && addr == AW'(OFS_TEST)) begin
      test_o <= wdata;
    end
  end

  assign rise_clr_o = (wr_en && addr == AW'(OFS_RISE)) ? wbits : '0;
  assign fall_clr_o = (wr_en && addr == AW'(OFS_FALL)) ? wbits : '0;
endmodule

// File: rtl/irq_src_front.sv
module irq_src_front
  import irq_sc_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] cfg0,
  input  logic [NSRC-1:0] cfg1,
  input  logic [NSRC-1:0] cfg2,
  input  logic [NSRC-1:0] rise_clr,
  input  logic [NSRC-1:0] fall_clr,
  output logic [NSRC-1:0] rise_en,
  output logic [NSRC-1:0] fall_en,
  output logic [NSRC-1:0] lvl_act,
  output logic [NSRC-1:0] rise_cap,
  output logic [NSRC-1:0] fall_cap
);
  logic [NSRC-1:0] meta_q, sync_q, prev_q;

  for (genvar k = 0; k < NSRC; k++) begin : g_dec
    logic [2:0] code;
    assign code       = {cfg2[k], cfg1[k], cfg0[k]};
    assign rise_en[k] = trig_rise_on(code);
    assign fall_en[k] = trig_fall_on(code);
    assign lvl_act[k] = ((code == TRIG_HIGH) &&  sync_q[k]) ||
                        ((code == TRIG_LOW)  && !sync_q[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      sync_q   <= '0;
      prev_q   <= '0;
      rise_cap <= '0;
      fall_cap <= '0;
    end else begin
      meta_q   <= src_in;
      sync_q   <= meta_q;
      prev_q   <= sync_q;
      // a fresh edge wins over a clear in the same cycle
      rise_cap <= (rise_cap & ~rise_clr) | (rise_en & sync_q & ~prev_q);
      fall_cap <= (fall_cap & ~fall_clr) | (fall_en & ~sync_q & prev_q);
    end
  end
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] lvl_act,
  input  logic [NSRC-1:0] rise_cap,
  input  logic [NSRC-1:0] fall_cap,
  input  logic [NSRC-1:0] rise_en,
  input  logic [NSRC-1:0] fall_en,
  input  logic [NSRC-1:0] mask,
  input  logic [NSRC-1:0] route,
  input  logic [NSRC-1:0] wake,
  output logic [NSRC-1:0] pend0,
  output logic [NSRC-1:0] pend1,
  output logic            req0_q,
  output logic            req1_q,
  output logic            wake_q
);
  logic [NSRC-1:0] active;

  assign active = mask & (lvl_act | (rise_cap & rise_en) | (fall_cap & fall_en));
  assign pend0  = active & ~route;
  assign pend1  = active & route;

  always_ff @(posedge clk) begin
    if (rst) begin
      req0_q <= 1'b0;
      req1_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      req0_q <= |pend0;
      req1_q <= |pend1;
      wake_q <= |(active & wake);
    end
  end
endmodule

// File: rtl/irq_setclr_ctrl.sv
module irq_setclr_ctrl
  import irq_sc_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_in,
  output logic            req0_o,
  output logic            req1_o,
  output logic            wake_o
);
  logic [SC_COUNT-1:0][NSRC-1:0] sc_v;
  logic [DW-1:0]   test_v;
  logic [NSRC-1:0] rise_clr_v, fall_clr_v;
  logic [NSRC-1:0] rise_en_v, fall_en_v, lvl_v;
  logic [NSRC-1:0] rise_cap_v, fall_cap_v;
  logic [NSRC-1:0] pend0_v, pend1_v;
  logic [NSRC-1:0] mask_v;
  logic [DW-1:0]   rd_next;

  assign mask_v = sc_v[IX_MASK];

  irq_sc_regs #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (bus_wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .sc_o       (sc_v),
    .test_o     (test_v),
    .rise_clr_o (rise_clr_v),
    .fall_clr_o (fall_clr_v)
  );

  irq_src_front #(.NSRC(NSRC)) u_front (
    .clk      (clk),
    .rst      (rst),
    .src_in   (src_in),
    .cfg0     (sc_v[IX_CFG0]),
    .cfg1     (sc_v[IX_CFG1]),
    .cfg2     (sc_v[IX_CFG2]),
    .rise_clr (rise_clr_v),
    .fall_clr (fall_clr_v),
    .rise_en  (rise_en_v),
    .fall_en  (fall_en_v),
    .lvl_act  (lvl_v),
    .rise_cap (rise_cap_v),
    .fall_cap (fall_cap_v)
  );

  irq_route #(.NSRC(NSRC)) u_route (
    .clk      (clk),
    .rst      (rst),
    .lvl_act  (lvl_v),
    .rise_cap (rise_cap_v),
    .fall_cap (fall_cap_v),
    .rise_en  (rise_en_v),
    .fall_en  (fall_en_v),
    .mask     (mask_v),
    .route    (sc_v[IX_ROUTE]),
    .wake     (sc_v[IX_WAKE]),
    .pend0    (pend0_v),
    .pend1    (pend1_v),
    .req0_q   (req0_o),
    .req1_q   (req1_o),
    .wake_q   (wake_o)
  );

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < SC_COUNT; i++) begin
      if (bus_addr == AW'(OFS_SC_BASE + OFS_SC_STRIDE * i)) rd_next = DW'(sc_v[i]);
    end
    if (bus_addr == AW'(OFS_PEND0)) rd_next = DW'(pend0_v);
    if (bus_addr == AW'(OFS_PEND1)) rd_next = DW'(pend1_v);
    if (bus_addr == AW'(OFS_RISE))  rd_next = DW'(rise_cap_v);
    if (bus_addr == AW'(OFS_FALL))  rd_next = DW'(fall_cap_v);
    if (bus_addr == AW'(OFS_TEST))  rd_next = test_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/irq_setclr_ctrl_chk.sv
module irq_setclr_ctrl_chk #(
  parameter int NSRC = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req0_o,
  input logic            req1_o,
  input logic            wake_o,
  input logic [NSRC-1:0] mask_v,
  input logic [NSRC-1:0] pend0_v,
  input logic [NSRC-1:0] pend1_v,
  input logic [NSRC-1:0] rise_cap_v,
  input logic [NSRC-1:0] rise_en_v
);
  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_v == '0) |=> (!req0_o && !req1_o));

  // R7
  req0_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (pend0_v == '0) |=> !req0_o);

  // R7
  req1_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (pend1_v == '0) |=> !req1_o);

  // R8
  wake_subset_chk: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> (req0_o || req1_o));

  // R5
  rise_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    ((rise_cap_v & ~$past(rise_cap_v) & ~$past(rise_en_v)) == '0));
endmodule

bind irq_setclr_ctrl irq_setclr_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req0_o     (req0_o),
  .req1_o     (req1_o),
  .wake_o     (wake_o),
  .mask_v     (mask_v),
  .pend0_v    (pend0_v),
  .pend1_v    (pend1_v),
  .rise_cap_v (rise_cap_v),
  .rise_en_v  (rise_en_v)
);

// File: tb/irq_setclr_ctrl_tb.sv
`timescale 1ns/1ps
module irq_setclr_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] src_in = '0;
  logic        req0_o, req1_o, wake_o;
  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_setclr_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 50000 && !done) begin
      nerr = nerr + 1;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nerr = nerr + 1;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cleanup();
    src_in = '0;
    waitn(5);
    wr(8'h44, '1); wr(8'h4C, '1); wr(8'h54, '1);
    wr(8'h64, '1); wr(8'h6C, '1); wr(8'h74, '1);
    wr(8'h78, '1); wr(8'h7C, '1);
    waitn(3);
  endtask

  task automatic t_reset();
    chk("R1 req0", req0_o, 0); chk("R1 req1", req1_o, 0); chk("R1 wake", wake_o, 0);
    rdchk("R1 cfg0", 8'h40, 0); rdchk("R1 cfg1", 8'h48, 0); rdchk("R1 cfg2", 8'h50, 0);
    rdchk("R1 src", 8'h58, 32'hFFFF_FFFF); rdchk("R1 route", 8'h60, 0);
    rdchk("R1 wake reg", 8'h68, 0); rdchk("R1 mask", 8'h70, 0);
    rdchk("R1 rise", 8'h78, 0); rdchk("R1 fall", 8'h7C, 0); rdchk("R1 test", 8'h80, 0);
  endtask

  task automatic t_setclr();
    wr(8'h60, 32'hF0F0_0000); wr(8'h60, 32'h0000_000F);
    rdchk("R2 route set", 8'h60, 32'hF0F0_000F);
    wr(8'h64, 32'h3000_0001);
    rdchk("R2 route clr", 8'h60, 32'hC0F0_000E);
    wr(8'h5C, 32'h0000_FFFF);
    rdchk("R2 src clr", 8'h58, 32'hFFFF_0000);
    wr(8'h58, 32'hFFFF_FFFF);
    rdchk("R2 src set", 8'h58, 32'hFFFF_FFFF);
    wr(8'h64, '1);
    rdchk("R2 route zero", 8'h60, 0);
    rdchk("R10 unmapped 44", 8'h44, 0);
    rdchk("R10 unmapped 84", 8'h84, 0);
  endtask

  task automatic t_level_high();
    wr(8'h50, 32'h8); wr(8'h40, 32'h8); wr(8'h70, 32'h8);
    src_in[3] = 1'b1;
    waitn(2); chk("R4 level early", req0_o, 0);
    waitn(1); chk("R4 R3 level high", req0_o, 1);
    rdchk("R7 pend0 level", 8'h54, 32'h8);
    src_in[3] = 1'b0;
    waitn(2); chk("R4 level hold", req0_o, 1);
    waitn(1); chk("R4 level drop", req0_o, 0);
    cleanup();
  endtask

  task automatic t_level_low();
    src_in[5] = 1'b1; waitn(4);
    wr(8'h50, 32'h20); wr(8'h48, 32'h20); wr(8'h70, 32'h20);
    waitn(1); chk("R3 low idle", req0_o, 0);
    src_in[5] = 1'b0;
    waitn(2); chk("R4 low early", req0_o, 0);
    waitn(1); chk("R3 level low", req0_o, 1);
    cleanup();
  endtask

  task automatic t_rise();
    wr(8'h40, 32'h80); wr(8'h70, 32'h80);
    src_in[7] = 1'b1;
    waitn(3); chk("R4 edge early", req0_o, 0);
    waitn(1); chk("R4 R3 rise", req0_o, 1);
    rdchk("R5 rise cap", 8'h78, 32'h80);
    src_in[7] = 1'b0; waitn(5);
    chk("R5 sticky", req0_o, 1);
    rdchk("R5 no fall cap", 8'h7C, 0);
    wr(8'h78, 32'h80);
    chk("R5 clr pending", req0_o, 1);
    waitn(1); chk("R5 rise cleared", req0_o, 0);
    cleanup();
  endtask

  task automatic t_fall();
    wr(8'h48, 32'h200); wr(8'h70, 32'h200);
    src_in[9] = 1'b1; waitn(5);
    rdchk("R5 rise ignored", 8'h78, 0);
    chk("R5 rise ignored req", req0_o, 0);
    src_in[9] = 1'b0;
    waitn(3); chk("R4 fall early", req0_o, 0);
    waitn(1); chk("R3 fall", req0_o, 1);
    wr(8'h7C, 32'h200); waitn(1);
    chk("R5 fall cleared", req0_o, 0);
    cleanup();
  endtask

  task automatic t_both_route();
    wr(8'h60, 32'h800); wr(8'h40, 32'h800); wr(8'h48, 32'h800); wr(8'h70, 32'h800);
    src_in[11] = 1'b1; waitn(4);
    chk("R7 req1 rise", req1_o, 1); chk("R7 req0 quiet", req0_o, 0);
    rdchk("R7 pend1", 8'h5C, 32'h800); rdchk("R7 pend0 empty", 8'h54, 0);
    wr(8'h78, 32'h800); waitn(1);
    chk("R5 both rise clr", req1_o, 0);
    src_in[11] = 1'b0; waitn(4);
    chk("R3 both fall", req1_o, 1);
    rdchk("R5 fall cap", 8'h7C, 32'h800);
    wr(8'h7C, 32'h800); waitn(1);
    chk("R5 both fall clr", req1_o, 0);
    cleanup();
  endtask

  task automatic t_disabled();
    wr(8'h50, 32'h8000); wr(8'h70, 32'h8000);
    src_in[15] = 1'b1; waitn(6);
    chk("R3 code 100", req0_o, 0);
    wr(8'h48, 32'h8000); wr(8'h40, 32'h8000); waitn(6);
    chk("R3 code 111", req0_o, 0);
    rdchk("R3 pend none", 8'h54, 0);
    cleanup();
  endtask

  task automatic t_mask_wake();
    wr(8'h50, 32'h2000); wr(8'h40, 32'h2000); wr(8'h68, 32'h2000);
    src_in[13] = 1'b1; waitn(4);
    chk("R6 masked req", req0_o, 0); chk("R8 masked wake", wake_o, 0);
    wr(8'h70, 32'h2000);
    chk("R6 unmask timing", req0_o, 0);
    waitn(1); chk("R6 unmask req", req0_o, 1); chk("R8 wake on", wake_o, 1);
    wr(8'h6C, 32'h2000); waitn(1);
    chk("R8 wake off", wake_o, 0); chk("R8 req stays", req0_o, 1);
    wr(8'h74, 32'h2000); waitn(1);
    chk("R6 remask", req0_o, 0);
    cleanup();
  endtask

  task automatic t_test_reg();
    wr(8'h80, 32'hA5A5_0F0F);
    rdchk("R9 test rb", 8'h80, 32'hA5A5_0F0F);
    waitn(2);
    chk("R9 no req0", req0_o, 0); chk("R9 no req1", req1_o, 0); chk("R9 no wake", wake_o, 0);
  endtask

  initial begin
    waitn(3);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_setclr();
    t_level_high();
    t_level_low();
    t_rise();
    t_fall();
    t_both_route();
    t_disabled();
    t_mask_wake();
    t_test_reg();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule